// File: doc/BRIEF.md
# Nested Priority-Level Preemption Controller

This block sits between a set of maskable interrupt sources and a processor core and gives the core true prioritized nesting. Software assigns each source a small priority level. The controller tracks the level of the routine that is currently executing, and it forwards a pending request to the core only when that request's level is strictly above the running level. Requests at or below the running level stay pending in their sources and are forwarded on their own once the running level drops below theirs.

The core reports with two single-cycle strobes. An entry strobe means it has taken the forwarded request. The controller then saves the running level on a small stack and adopts the new routine's level. A return strobe means the routine has finished. The controller then restores the saved level, so the preempted lower-priority work resumes under its own level. The core's global maskable disable is cleared on entry to every routine, and filtering relies on this block alone.

An optional non-maskable-class source ranks above every level that software can assign. Pushing onto a full stack sets a sticky overflow flag. While that flag is set, no further preemption takes place.

Top module: `nested_prio_ctrl`

## Requirements
- R1: After reset the running level is 0 (background), no request is forwarded, and the overflow flag is low.
- R2: A source programmed to level 0 is never forwarded, whatever its request line does.
- R3: A request is forwarded (fwdValid high) only if its level is strictly greater than the running level. Requests at equal or lower levels stay unforwarded.
- R4: Among forwardable requests, the one with the highest level is chosen. Among requests of the same level, the one with the higher source index is chosen. fwdIdx carries the chosen source number.
- R5: An entry strobe while fwdValid is high saves the running level on the stack. From the next cycle, the running level equals the forwarded request's level.
- R6: A return strobe restores the most recently saved level in the next cycle. A return strobe with an empty stack leaves the running level unchanged.
- R7: A request that is held because its level is not above the running level is forwarded with no further stimulus as soon as the running level falls below its level.
- R8: When nmiEn and nmiReq are both high, the non-maskable source is chosen with fwdIdx = NUM_SRC and effective level 2^LVL_W. That level lies above every assignable level. With nmiEn low, nmiReq has no effect.
- R9: An entry strobe while the stack already holds DEPTH levels pushes nothing and leaves the running level unchanged. It sets overflow, which stays high until reset. While overflow is high, fwdValid is low.
- R10: Without a return strobe, the running level changes only on an accepted entry. An entry strobe while fwdValid is low is ignored. If entry and return arrive together, the entry is handled and the return is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqIn | input | NUM_SRC | Request line of each maskable source |
| srcLevel | input | NUM_SRC*LVL_W | Priority level per source, source i in bits [i*LVL_W +: LVL_W] |
| nmiEn | input | 1 | Enables the non-maskable-class source |
| nmiReq | input | 1 | Non-maskable-class request |
| entryStb | input | 1 | Core has entered the forwarded routine |
| retStb | input | 1 | Core has returned from the current routine |
| fwdValid | output | 1 | A request is being forwarded to the core |
| fwdIdx | output | $clog2(NUM_SRC+1) | Index of the chosen source (NUM_SRC for the non-maskable source) |
| curLevel | output | LVL_W+1 | Level of the running routine |
| overflow | output | 1 | Sticky level-stack overflow |

## Verification
The properties assume that the core strobes entry or return for one cycle at a time and only in response to this block's outputs. They also assume that the level inputs stay steady while a strobe is being handled, so that a forwarded level compared across one edge refers to the same programming. The bench keeps all levels fixed through each sequence and drives strobes on falling edges, one per cycle. It also deliberately sends an entry with nothing forwarded and a return with an empty stack, which the design must tolerate. The stack depth is reduced in the bench so that overflow can be reached with strictly rising levels.

// File: rtl/npc_pkg.sv
package npc_pkg;
  typedef struct packed {
    logic push;
    logic pop;
  } stackCmd_t;
endpackage

// File: rtl/npc_datapath.sv
module npc_datapath
  import npc_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int LVL_W   = 3,
  parameter int DEPTH   = 8,
  localparam int IDX_W  = $clog2(NUM_SRC + 1),
  localparam int EFF_W  = LVL_W + 1,
  localparam int PTR_W  = $clog2(DEPTH + 1),
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_SRC-1:0]       reqIn,
  input  logic [NUM_SRC*LVL_W-1:0] srcLevel,
  input  logic                     nmiEn,
  input  logic                     nmiReq,
  input  stackCmd_t                cmd,
  input  logic [PTR_W-1:0]         ptr,
  output logic                     bestValid,
  output logic [IDX_W-1:0]         bestIdx,
  output logic [EFF_W-1:0]         bestLevel,
  output logic [EFF_W-1:0]         curLevel
);
  localparam logic [EFF_W-1:0] NMI_LVL = {1'b1, {LVL_W{1'b0}}};

  logic [LVL_W-1:0] lvlArr [NUM_SRC];
  logic [NUM_SRC-1:0] eligible;

  for (genvar g = 0; g < NUM_SRC; g++) begin : gSrc
    assign lvlArr[g]   = srcLevel[g*LVL_W +: LVL_W];
    assign eligible[g] = reqIn[g] && (lvlArr[g] != '0);
  end

  // Ascending scan with >= so a later (higher) index wins a tie.
  always_comb begin
    bestValid = 1'b0;
    bestIdx   = '0;
    bestLevel = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (eligible[i] && ({1'b0, lvlArr[i]} >= bestLevel)) begin
        bestValid = 1'b1;
        bestIdx   = IDX_W'(i);
        bestLevel = {1'b0, lvlArr[i]};
      end
    end
    if (nmiEn && nmiReq) begin
      bestValid = 1'b1;
      bestIdx   = IDX_W'(NUM_SRC);
      bestLevel = NMI_LVL;
    end
  end

  logic [EFF_W-1:0]  stackMem [DEPTH];
  logic [ADDR_W-1:0] wrAddr;
  logic [ADDR_W-1:0] topAddr;

  assign wrAddr  = ADDR_W'(ptr);
  assign topAddr = ADDR_W'(ptr - PTR_W'(1));

  always_ff @(posedge clk) begin
    if (cmd.push) stackMem[wrAddr] <= curLevel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         curLevel <= '0;
    else if (cmd.push) curLevel <= bestLevel;
    else if (cmd.pop)  curLevel <= stackMem[topAddr];
  end
endmodule

// File: rtl/npc_control.sv
module npc_control
  import npc_pkg::*;
#(
  parameter int LVL_W  = 3,
  parameter int DEPTH  = 8,
  localparam int EFF_W = LVL_W + 1,
  localparam int PTR_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             entryStb,
  input  logic             retStb,
  input  logic             bestValid,
  input  logic [EFF_W-1:0] bestLevel,
  input  logic [EFF_W-1:0] curLevel,
  output stackCmd_t        cmd,
  output logic [PTR_W-1:0] ptr,
  output logic             fwdValid,
  output logic             overflow
);
  logic stackFull, stackEmpty, ovfSet;

  assign stackFull  = (ptr == PTR_W'(DEPTH));
  assign stackEmpty = (ptr == '0);
  assign fwdValid   = bestValid && (bestLevel > curLevel) && !overflow;
  assign cmd.push   = entryStb && fwdValid && !stackFull;
  assign cmd.pop    = retStb && !entryStb && !stackEmpty;
  assign ovfSet     = entryStb && fwdValid && stackFull;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr      <= '0;
      overflow <= 1'b0;
    end else begin
      if (cmd.push)     ptr <= ptr + PTR_W'(1);
      else if (cmd.pop) ptr <= ptr - PTR_W'(1);
      if (ovfSet) overflow <= 1'b1;
    end
  end
endmodule

// File: rtl/nested_prio_ctrl.sv
module nested_prio_ctrl
  import npc_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int LVL_W   = 3,
  parameter int DEPTH   = 8,
  localparam int IDX_W  = $clog2(NUM_SRC + 1),
  localparam int EFF_W  = LVL_W + 1,
  localparam int PTR_W  = $clog2(DEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_SRC-1:0]       reqIn,
  input  logic [NUM_SRC*LVL_W-1:0] srcLevel,
  input  logic                     nmiEn,
  input  logic                     nmiReq,
  input  logic                     entryStb,
  input  logic                     retStb,
  output logic                     fwdValid,
  output logic [IDX_W-1:0]         fwdIdx,
  output logic [EFF_W-1:0]         curLevel,
  output logic                     overflow
);
  stackCmd_t        cmd;
  logic [PTR_W-1:0] ptr;
  logic             bestValid;
  logic [EFF_W-1:0] bestLevel;

  npc_datapath #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .DEPTH(DEPTH)) uDp (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .srcLevel(srcLevel),
    .nmiEn(nmiEn), .nmiReq(nmiReq), .cmd(cmd), .ptr(ptr),
    .bestValid(bestValid), .bestIdx(fwdIdx), .bestLevel(bestLevel),
    .curLevel(curLevel)
  );

  npc_control #(.LVL_W(LVL_W), .DEPTH(DEPTH)) uCtl (
    .clk(clk), .rstN(rstN), .entryStb(entryStb), .retStb(retStb),
    .bestValid(bestValid), .bestLevel(bestLevel), .curLevel(curLevel),
    .cmd(cmd), .ptr(ptr), .fwdValid(fwdValid), .overflow(overflow)
  );
endmodule

// File: rtl/npc_checker.sv
module npc_checker #(
  parameter int NUM_SRC = 8,
  parameter int LVL_W   = 3,
  localparam int IDX_W  = $clog2(NUM_SRC + 1),
  localparam int EFF_W  = LVL_W + 1
) (
  input logic                     clk,
  input logic                     rstN,
  input logic [NUM_SRC-1:0]       reqIn,
  input logic [NUM_SRC*LVL_W-1:0] srcLevel,
  input logic                     nmiEn,
  input logic                     nmiReq,
  input logic                     entryStb,
  input logic                     retStb,
  input logic                     fwdValid,
  input logic [IDX_W-1:0]         fwdIdx,
  input logic [EFF_W-1:0]         curLevel,
  input logic                     overflow
);
  localparam logic [EFF_W-1:0] NMI_LVL = {1'b1, {LVL_W{1'b0}}};

  logic [EFF_W-1:0] fwdSrcLvl;
  logic             fwdSrcReq;
  logic             isSrc;

  always_comb begin
    fwdSrcLvl = '0;
    fwdSrcReq = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (fwdIdx == IDX_W'(i)) begin
        fwdSrcLvl = {1'b0, srcLevel[i*LVL_W +: LVL_W]};
        fwdSrcReq = reqIn[i];
      end
    end
  end
  assign isSrc = (fwdIdx < IDX_W'(NUM_SRC));

  assert_src_live_R2: assert property (@(posedge clk) disable iff (!rstN)
    fwdValid && isSrc |-> fwdSrcReq && (fwdSrcLvl != '0));

  assert_strictly_higher_R3: assert property (@(posedge clk) disable iff (!rstN)
    fwdValid && isSrc |-> fwdSrcLvl > curLevel);

  assert_entry_raises_R5: assert property (@(posedge clk) disable iff (!rstN)
    entryStb && fwdValid |=> overflow || (curLevel > $past(curLevel)));

  assert_return_lowers_R6: assert property (@(posedge clk) disable iff (!rstN)
    retStb && !entryStb && (curLevel != '0) |=> curLevel < $past(curLevel));

  assert_nmi_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
    nmiEn && nmiReq && !overflow && (curLevel != NMI_LVL)
      |-> fwdValid && (fwdIdx == IDX_W'(NUM_SRC)));

  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);

  assert_ovf_blocks_R9: assert property (@(posedge clk) disable iff (!rstN)
    overflow |-> !fwdValid);

  assert_level_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !retStb && !(entryStb && fwdValid) |=> $stable(curLevel));
endmodule

bind nested_prio_ctrl npc_checker #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) uChk (
  .clk(clk), .rstN(rstN), .reqIn(reqIn), .srcLevel(srcLevel),
  .nmiEn(nmiEn), .nmiReq(nmiReq), .entryStb(entryStb), .retStb(retStb),
  .fwdValid(fwdValid), .fwdIdx(fwdIdx), .curLevel(curLevel),
  .overflow(overflow)
);

// File: tb/sim_nested_prio_ctrl.sv
`timescale 1ns/1ps
module sim_nested_prio_ctrl;
  localparam int NS = 8;
  localparam int LW = 3;
  localparam int DP = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NS-1:0] reqIn = '0;
  logic [NS*LW-1:0] srcLevel;
  logic nmiEn = 1'b1, nmiReq = 1'b0, entryStb = 1'b0, retStb = 1'b0;
  logic fwdValid, overflow;
  logic [3:0] fwdIdx;
  logic [3:0] curLevel;
  int nChecks = 0, nFails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  // Levels, src7..src0: 2,7,0,5,3,3,2,1
  assign srcLevel = {3'd2, 3'd7, 3'd0, 3'd5, 3'd3, 3'd3, 3'd2, 3'd1};

  nested_prio_ctrl #(.NUM_SRC(NS), .LVL_W(LW), .DEPTH(DP)) u0 (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .srcLevel(srcLevel),
    .nmiEn(nmiEn), .nmiReq(nmiReq), .entryStb(entryStb), .retStb(retStb),
    .fwdValid(fwdValid), .fwdIdx(fwdIdx), .curLevel(curLevel),
    .overflow(overflow)
  );

  // {req[7:0], nmi, ent, ret, expValid, expIdx[3:0], expLevel[3:0]}
  localparam logic [19:0] VEC [16] = '{
    {8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 4'd0}, // R1 idle
    {8'h20, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 4'd0}, // R2 level-0 source
    {8'h01, 1'b0, 1'b1, 1'b0, 1'b1, 4'd0, 4'd0}, // R3 lvl1 > 0
    {8'h03, 1'b0, 1'b1, 1'b0, 1'b1, 4'd1, 4'd1}, // R5 nest to 2
    {8'h83, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 4'd2}, // R3 equal held
    {8'h0D, 1'b0, 1'b1, 1'b0, 1'b1, 4'd3, 4'd2}, // R4 tie -> src3
    {8'h04, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 4'd3}, // R6 return
    {8'h04, 1'b0, 1'b0, 1'b0, 1'b1, 4'd2, 4'd2}, // R7 auto-forward
    {8'h44, 1'b0, 1'b1, 1'b0, 1'b1, 4'd6, 4'd2}, // R4 highest level
    {8'h04, 1'b1, 1'b1, 1'b0, 1'b1, 4'd8, 4'd7}, // R8 nmi over 7
    {8'h40, 1'b1, 1'b0, 1'b1, 1'b0, 4'd0, 4'd8}, // R8 nmi running
    {8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 4'd7}, // R6 pop -> 2
    {8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 4'd2}, // R6 pop -> 1
    {8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 4'd1}, // R6 pop -> 0
    {8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 4'd0}, // R6 empty return
    {8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 4'd0}  // R6 still 0
  };

  task automatic check(string tag, logic expV, logic [3:0] expIdx,
                       logic [3:0] expLvl, logic expOvf);
    nChecks++;
    if (fwdValid !== expV || (expV && fwdIdx !== expIdx) ||
        curLevel !== expLvl || overflow !== expOvf) begin
      nFails++;
      $display("FAIL %s: valid/idx/level/ovf = %0b/%0d/%0d/%0b expected %0b/%0d/%0d/%0b",
               tag, fwdValid, fwdIdx, curLevel, overflow, expV, expIdx, expLvl, expOvf);
    end
  endtask

  task automatic drive(logic [7:0] r, logic n, logic e, logic t);
    @(negedge clk);
    reqIn = r; nmiReq = n; entryStb = e; retStb = t;
    #1;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; reqIn = '0; nmiReq = 1'b0; entryStb = 1'b0; retStb = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    check("R1 reset", 1'b0, 4'd0, 4'd0, 1'b0);

    for (int k = 0; k < 16; k++) begin
      drive(VEC[k][19:12], VEC[k][11], VEC[k][10], VEC[k][9]);
      check($sformatf("vector %0d (R2..R8)", k), VEC[k][8], VEC[k][7:4], VEC[k][3:0], 1'b0);
    end

    // R8: nmiEn low makes nmiReq ineffective
    nmiEn = 1'b0;
    drive(8'h00, 1'b1, 1'b0, 1'b0);
    check("R8 nmi disabled", 1'b0, 4'd0, 4'd0, 1'b0);
    nmiEn = 1'b1;

    // R10: entry with nothing forwarded is ignored
    drive(8'h00, 1'b0, 1'b1, 1'b0);
    drive(8'h00, 1'b0, 1'b0, 1'b0);
    check("R10 stray entry", 1'b0, 4'd0, 4'd0, 1'b0);

    // R10: simultaneous entry and return, entry wins
    drive(8'h01, 1'b0, 1'b1, 1'b1);
    drive(8'h00, 1'b0, 1'b0, 1'b0);
    check("R10 entry beats return", 1'b0, 4'd0, 4'd1, 1'b0);
    drive(8'h00, 1'b0, 1'b0, 1'b1);
    drive(8'h00, 1'b0, 1'b0, 1'b0);
    check("R6 back to background", 1'b0, 4'd0, 4'd0, 1'b0);

    // R9: fill the 4-deep stack, then one more entry
    drive(8'h01, 1'b0, 1'b1, 1'b0);
    drive(8'h02, 1'b0, 1'b1, 1'b0);
    drive(8'h04, 1'b0, 1'b1, 1'b0);
    drive(8'h10, 1'b0, 1'b1, 1'b0);
    drive(8'h40, 1'b0, 1'b0, 1'b0);
    check("R9 full stack still forwards", 1'b1, 4'd6, 4'd5, 1'b0);
    drive(8'h40, 1'b0, 1'b1, 1'b0);
    drive(8'h40, 1'b0, 1'b0, 1'b0);
    check("R9 overflow set and blocks", 1'b0, 4'd0, 4'd5, 1'b1);
    drive(8'h40, 1'b1, 1'b0, 1'b0);
    check("R9 overflow blocks nmi", 1'b0, 4'd0, 4'd5, 1'b1);
    drive(8'h40, 1'b0, 1'b0, 1'b1);
    drive(8'h40, 1'b0, 1'b0, 1'b0);
    check("R9 overflow sticky after return", 1'b0, 4'd0, 4'd3, 1'b1);

    doReset();
    #1;
    check("R1 reset clears overflow", 1'b0, 4'd0, 4'd0, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule